// File: doc/BRIEF.md
# Four-Queue Egress Scheduler with Movable Strict-Priority Boundary

This block picks which of four output queues of one egress port may send its next frame. Queue 3 has the highest rank and queue 0 the lowest. A two-bit mode, taken from a wider egress control word, sets how many of the top queues are served by plain strict priority. The queues below that boundary share the link by credit-based weighted round robin, where each credit is one frame.

The block reads four queue-not-empty flags and returns a one-hot grant with a valid flag. The transmitter holds the grant for the whole frame and pulses a frame-done strobe on its last cycle. A new choice is made only when the port is idle or on that strobe, so a frame is never cut short. A hold-off input from the rate shaper blocks new grants without ending the current one.

Top module: `eqs_sched`

## Requirements
- R1: After synchronous reset, grant is 0000, grant_valid is low, and every queue's credit is full, so the first weighted round starts with each queue's full weight.
- R2: grant is one-hot whenever grant_valid is high and all-zero whenever it is low (bit n of grant stands for queue n).
- R3: A choice is made only on a clock edge where the port is idle or frame_done is high. The grant then appears in the following cycle, with no idle cycle between back-to-back frames. A granted queue keeps its grant, even if a higher queue fills, until frame_done.
- R4: While hold_off is high, no new grant is issued. A grant already in progress stays until frame_done, after which grant_valid goes low until hold_off falls.
- R5: The mode is ctrl_word[13:12]. All other control bits have no effect on the grant order.
- R6: Mode 11 serves every queue by strict priority, queue 3 first, then 2, 1, 0.
- R7: Mode 01 serves queue 3 strictly ahead of all others. Queues 2, 1 and 0 share by weighted round robin.
- R8: Mode 10 serves queue 3 and then queue 2 strictly. Queues 1 and 0 share by weighted round robin.
- R9: Mode 00 puts all four queues under weighted round robin. The default weights are 8, 4, 2 and 1 frames for queues 3, 2, 1 and 0. Within a round, the highest-numbered non-empty queue that still has credit is served first.
- R10: Empty queues are skipped. A new round starts when no non-empty weighted queue has credit left. At that point every credit is set back to its weight, not added to it, so unused credit is lost.
- R11: With no non-empty eligible queue, grant_valid stays low, and a frame_done pulse while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 16 | Egress control word; bits 13:12 hold the schedule mode |
| q_nonempty | input | 4 | Per-queue not-empty flags, bit n for queue n |
| frame_done | input | 1 | Strobe on the last cycle of the granted frame |
| hold_off | input | 1 | Rate shaper request to issue no new grant |
| grant | output | 4 | One-hot granted queue |
| grant_valid | output | 1 | A grant is held |

## Verification
The hardest case to reach is a round boundary where a queue went empty while it still had credit. The difference between resetting and carrying over that credit only shows up when the queue refills in the next round. The stimulus runs weighted mode with queue 3 empty until queues 2 to 0 are drained of credit and a new round has started. It then fills queue 3 and counts its consecutive grants, expecting exactly its weight. Non-preemption is reached the same way: a low queue is granted first, then higher queues fill and the mode switches while frame_done stays low.

// File: rtl/eqs_pkg.sv
package eqs_pkg;

    localparam int NQ       = 4;
    localparam int MODE_LSB = 12;

    typedef logic [NQ-1:0] qvec_t;

    typedef enum logic [1:0] {
        MODE_NONE = 2'b00,
        MODE_TOP1 = 2'b01,
        MODE_TOP2 = 2'b10,
        MODE_ALL  = 2'b11
    } sched_mode_e;

    typedef struct packed {
        logic  hit;
        qvec_t sel;
    } pick_t;

    // Queues served strictly for a given mode (upper queues first).
    function automatic qvec_t strict_mask(sched_mode_e m);
        case (m)
            MODE_TOP1: return 4'b1000;
            MODE_TOP2: return 4'b1100;
            MODE_ALL:  return 4'b1111;
            default:   return 4'b0000;
        endcase
    endfunction

    // One-hot of the highest set bit.
    function automatic qvec_t pick_highest(qvec_t v);
        qvec_t r = '0;
        for (int i = 0; i < NQ; i++) begin
            if (v[i]) r = qvec_t'(1) << i;
        end
        return r;
    endfunction

endpackage

// File: rtl/eqs_strict_pick.sv
module eqs_strict_pick
    import eqs_pkg::*;
(
    input  qvec_t req,
    output pick_t pick
);
    qvec_t sel;

    generate
        for (genvar i = 0; i < NQ; i++) begin : g_chain
            if (i == NQ - 1) begin : g_top
                assign sel[i] = req[i];
            end else begin : g_low
                assign sel[i] = req[i] & ~(|req[NQ-1:i+1]);
            end
        end
    endgenerate

    assign pick.sel = sel;
    assign pick.hit = |req;
endmodule

// File: rtl/eqs_wrr_credit.sv
module eqs_wrr_credit
    import eqs_pkg::*;
#(
    parameter int                         CW      = 4,
    parameter logic [NQ-1:0][CW-1:0]      WEIGHTS = {4'd8, 4'd4, 4'd2, 4'd1}
) (
    input  logic  clk,
    input  logic  rst,
    input  qvec_t cand,
    input  logic  take,
    output pick_t pick
);
    logic [CW-1:0] credit [NQ];
    qvec_t has_cr;
    qvec_t elig;
    qvec_t pool;
    logic  refill;

    generate
        for (genvar i = 0; i < NQ; i++) begin : g_cr
            assign has_cr[i] = (credit[i] != '0);
        end
    endgenerate

    assign elig   = cand & has_cr;
    assign refill = (elig == '0);
    assign pool   = refill ? cand : elig;

    assign pick.sel = pick_highest(pool);
    assign pick.hit = |cand;

    generate
        for (genvar i = 0; i < NQ; i++) begin : g_upd
            always_ff @(posedge clk) begin
                if (rst) begin
                    credit[i] <= WEIGHTS[i];
                end else if (take) begin
                    if (refill)
                        credit[i] <= WEIGHTS[i] - (pick.sel[i] ? CW'(1) : CW'(0));
                    else if (pick.sel[i])
                        credit[i] <= credit[i] - CW'(1);
                end
            end

            // R10: credit is reloaded, never accumulated past its weight
            p_credit_bound_r10: assert property (@(posedge clk) disable iff (rst)
                credit[i] <= WEIGHTS[i]);
        end
    endgenerate
endmodule

// File: rtl/eqs_sched.sv
module eqs_sched
    import eqs_pkg::*;
#(
    parameter int                         CTRL_W  = 16,
    parameter int                         CW      = 4,
    parameter logic [NQ-1:0][CW-1:0]      WEIGHTS = {4'd8, 4'd4, 4'd2, 4'd1}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [NQ-1:0]     q_nonempty,
    input  logic              frame_done,
    input  logic              hold_off,
    output logic [NQ-1:0]     grant,
    output logic              grant_valid
);
    sched_mode_e mode;
    qvec_t       smask;
    pick_t       s_pick;
    pick_t       w_pick;
    logic        slot_free;
    logic        take;
    logic        wrr_take;
    qvec_t       next_grant;
    logic        unused_ctrl;

    assign mode        = sched_mode_e'(ctrl_word[MODE_LSB +: 2]);
    assign unused_ctrl = ^{ctrl_word[CTRL_W-1:MODE_LSB+2], ctrl_word[MODE_LSB-1:0]};
    assign smask       = strict_mask(mode);

    eqs_strict_pick u_strict (
        .req  (q_nonempty & smask),
        .pick (s_pick)
    );

    eqs_wrr_credit #(.CW(CW), .WEIGHTS(WEIGHTS)) u_wrr (
        .clk  (clk),
        .rst  (rst),
        .cand (q_nonempty & ~smask),
        .take (wrr_take),
        .pick (w_pick)
    );

    assign slot_free  = !grant_valid || frame_done;
    assign take       = slot_free && !hold_off && (s_pick.hit || w_pick.hit);
    assign wrr_take   = take && !s_pick.hit;
    assign next_grant = s_pick.hit ? s_pick.sel : w_pick.sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant       <= '0;
            grant_valid <= 1'b0;
        end else if (take) begin
            grant       <= next_grant;
            grant_valid <= 1'b1;
        end else if (slot_free) begin
            grant       <= '0;
            grant_valid <= 1'b0;
        end
    end

    // R2
    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        grant_valid == $onehot(grant));
    p_zero_idle_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    // R3
    p_no_preempt_r3: assert property (@(posedge clk) disable iff (rst)
        grant_valid && !frame_done |=> grant_valid && $stable(grant));
    // R4
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        hold_off |=> !grant_valid || $stable(grant));
    // R7
    p_strict_top_r7: assert property (@(posedge clk) disable iff (rst)
        take && mode != MODE_NONE && q_nonempty[3] |=> grant[3]);
    // R6
    p_all_strict_r6: assert property (@(posedge clk) disable iff (rst)
        take && mode == MODE_ALL && q_nonempty[2] && !q_nonempty[3] |=> grant[2]);
    // R11
    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        slot_free && q_nonempty == '0 |=> !grant_valid);
endmodule

// File: tb/eqs_sched_test.sv
module eqs_sched_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ctrl_word = '0;
    logic [3:0]  q_nonempty = '0;
    logic        frame_done = 1'b0;
    logic        hold_off = 1'b0;
    logic [3:0]  grant;
    logic        grant_valid;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eqs_sched uut (
        .clk        (clk),
        .rst        (rst),
        .ctrl_word  (ctrl_word),
        .q_nonempty (q_nonempty),
        .frame_done (frame_done),
        .hold_off   (hold_off),
        .grant      (grant),
        .grant_valid(grant_valid)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst = 1'b1; q_nonempty = '0; frame_done = 1'b0; hold_off = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic expect_grant(input int q, input string tag);
        check(grant_valid && grant == 4'(1 << q), tag,
              {27'd0, grant_valid, grant}, {27'd0, 1'b1, 4'(1 << q)});
    endtask

    task automatic expect_idle(input string tag);
        check(!grant_valid && grant == 4'b0000, tag, {27'd0, grant_valid, grant}, 0);
    endtask

    task automatic finish_frame();
        frame_done = 1'b1;
        tick();
        frame_done = 1'b0;
    endtask

    // Each digit is the queue expected to hold the grant for one frame.
    task automatic serve_seq(input string tag, input string pattern);
        for (int k = 0; k < pattern.len(); k++) begin
            expect_grant(int'(pattern[k]) - 48, tag);
            finish_frame();
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick();
        expect_idle("R1 reset state");
        tick();
        expect_idle("R1 reset held");
        rst = 1'b0;
    endtask

    task automatic t_wrr_all();
        do_reset();
        ctrl_word = 16'h0000;
        q_nonempty = 4'b1111;
        tick();
        serve_seq("R9 R1 R2 weighted all", "3333333322221103333");
    endtask

    task automatic t_ctrl_ignored();
        do_reset();
        ctrl_word = 16'hCFFF;
        q_nonempty = 4'b1111;
        tick();
        serve_seq("R5 other control bits", "3333333322221103");
    endtask

    task automatic t_top1();
        do_reset();
        ctrl_word = 16'h1000;
        q_nonempty = 4'b1111;
        tick();
        serve_seq("R7 q3 strict", "333");
        q_nonempty = 4'b0111;
        serve_seq("R7 lower weighted", "3222211022");
    endtask

    task automatic t_top2();
        do_reset();
        ctrl_word = 16'h2000;
        q_nonempty = 4'b1111;
        tick();
        serve_seq("R8 q3 strict", "33");
        q_nonempty = 4'b0111;
        serve_seq("R8 q2 strict", "3222");
        q_nonempty = 4'b0011;
        serve_seq("R8 q1 q0 weighted", "2110110");
    endtask

    task automatic t_all_strict();
        do_reset();
        ctrl_word = 16'h3000;
        q_nonempty = 4'b1111;
        tick();
        serve_seq("R6 strict q3", "3333");
        q_nonempty = 4'b0110;
        serve_seq("R6 strict q2", "3222");
        q_nonempty = 4'b0011;
        serve_seq("R6 strict q1", "211");
        q_nonempty = 4'b0001;
        serve_seq("R6 strict q0", "1000");
    endtask

    task automatic t_no_carry();
        do_reset();
        ctrl_word = 16'h0000;
        q_nonempty = 4'b0111;
        tick();
        serve_seq("R10 q3 empty skipped", "2222110");
        q_nonempty = 4'b1111;
        // q3 gets exactly its weight (8), not 16
        serve_seq("R10 credit reset not carried", "23333333322211" );
        serve_seq("R10 round end", "03");
    endtask

    task automatic t_no_preempt();
        do_reset();
        ctrl_word = 16'h0000;
        q_nonempty = 4'b0001;
        tick();
        expect_grant(0, "R3 low queue granted");
        q_nonempty = 4'b1111;
        ctrl_word = 16'h3000;
        for (int c = 0; c < 3; c++) begin
            tick();
            expect_grant(0, "R3 no preemption");
        end
        finish_frame();
        expect_grant(3, "R3 back-to-back after frame_done");
    endtask

    task automatic t_hold();
        do_reset();
        ctrl_word = 16'h3000;
        hold_off = 1'b1;
        q_nonempty = 4'b1111;
        for (int c = 0; c < 4; c++) begin
            tick();
            expect_idle("R4 hold blocks grant");
        end
        hold_off = 1'b0;
        tick();
        expect_grant(3, "R4 grant after release");
        hold_off = 1'b1;
        tick();
        expect_grant(3, "R4 grant kept under hold");
        tick();
        expect_grant(3, "R4 grant kept under hold");
        finish_frame();
        expect_idle("R4 idle after frame under hold");
        tick();
        expect_idle("R4 still idle under hold");
        hold_off = 1'b0;
        tick();
        expect_grant(3, "R4 resumes");
    endtask

    task automatic t_empty();
        do_reset();
        ctrl_word = 16'h0000;
        q_nonempty = 4'b0000;
        tick();
        expect_idle("R11 nothing to send");
        frame_done = 1'b1;
        tick();
        frame_done = 1'b0;
        expect_idle("R11 stray frame_done");
        tick();
        expect_idle("R11 stray frame_done after");
        q_nonempty = 4'b0010;
        tick();
        expect_grant(1, "R11 single queue");
        q_nonempty = 4'b0000;
        finish_frame();
        expect_idle("R11 drained");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2;
        t_reset();
        t_wrr_all();
        t_ctrl_ignored();
        t_top1();
        t_top2();
        t_all_strict();
        t_no_carry();
        t_no_preempt();
        t_hold();
        t_empty();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule